// File: doc/BRIEF.md
# Data-Space Decoder and Stack Unit

This unit sits between a small processor core and its data space. A 16-bit data-space address is sorted into one of three regions: the 32-byte working-register window, the 64-entry peripheral register window, or on-chip SRAM. The unit returns the matching read byte one cycle after a read strobe. Register-file and peripheral data come from outside through two input buses. SRAM data comes from a synchronous memory inside the unit.

The unit also holds a 16-bit stack pointer. The stack lives in SRAM and grows toward lower addresses. It supports single-byte push and pop. It also supports two-byte saving and restoring of a return program counter for subroutine calls and interrupt entry. Software reads and writes the pointer as two bytes inside the peripheral window, and must load it before any call. The state machine has four states. ST_IDLE accepts every request. ST_PUSH_HI writes the second byte of a return address and then goes back to ST_IDLE. A return pop goes ST_IDLE → ST_POP_LO → ST_POP_DONE → ST_IDLE: the first read fetches the high byte, ST_POP_LO reads the low byte, and ST_POP_DONE assembles the address. When the state machine is in ST_IDLE, requests are served in this priority order: return-address push, return-address pop, byte push, byte pop, bus access.

Top module: `ds_stack_unit`

## Requirements
- R1: Addresses 0x0000–0x001F raise only `sel_rf`. A read there returns the `rf_rdata` value sampled at the read edge, on `rdata` one cycle later.
- R2: Addresses 0x0020–0x005F raise only `sel_io`, and `io_addr` equals address minus 0x20. A read returns the sampled `io_rdata` one cycle later, except at the two stack-pointer locations.
- R3: Addresses 0x0060 to 0x0060+SRAM_DEPTH-1 raise only `sel_sram`. A byte written there reads back one cycle after the read strobe. Higher addresses select no region and read as 0x00.
- R4: After reset the stack pointer is 0x0000 and `busy`/`ret_valid` are low. `sp_err` is high exactly while the pointer is below 0x0060.
- R5: The pointer's low byte sits at data address 0x005D (peripheral index 0x3D) and its high byte at 0x005E (index 0x3E). A write sets that byte at the next edge, and a read returns it one cycle later.
- R6: A byte push stores `wdata` at SRAM[SP] and decrements SP, all in one cycle.
- R7: A byte pop increments SP, and one cycle later `rdata` shows SRAM at the new SP.
- R8: A return-address push stores bits 7:0 at SP and bits 15:8 at SP-1, leaves SP lowered by two, and holds `busy` high for exactly one cycle.
- R9: A return-address pop raises SP by two, keeps `busy` high for two cycles, and pulses `ret_valid` for one cycle, three cycles after the request, with the restored address on `ret_addr_out`.
- R10: Requests made while `busy` is high have no effect. A bus access in the same cycle as any stack request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Data-space address |
| wdata | input | 8 | Bus write data and byte-push data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rf_rdata | input | 8 | Read byte from the register file |
| io_rdata | input | 8 | Read byte from peripherals |
| push | input | 1 | Byte push request |
| pop | input | 1 | Byte pop request |
| call_push | input | 1 | Return-address push request |
| ret_pop | input | 1 | Return-address pop request |
| ret_addr_in | input | 16 | Return address to save |
| rdata | output | 8 | Read data, one cycle after the strobe |
| sel_rf | output | 1 | Address decodes to the register file |
| sel_io | output | 1 | Address decodes to the peripheral window |
| sel_sram | output | 1 | Address decodes to SRAM |
| io_addr | output | 6 | Peripheral register index |
| ret_addr_out | output | 16 | Restored return address |
| ret_valid | output | 1 | One-cycle strobe for `ret_addr_out` |
| sp_out | output | 16 | Current stack pointer |
| sp_err | output | 1 | Pointer is below the SRAM base |
| busy | output | 1 | Multi-cycle stack operation in progress |

## Verification
The region selects and `io_addr` are combinational, so they are checked in the same cycle as the address. Read data, the pointer after a push or pop, and a pointer byte write all appear after the next rising edge, so the bench samples them at the following falling edge. A return-address push is checked one and two falling edges after the request. A return-address pop is checked at the first, second and third falling edges, and its strobe is checked again at the fourth to confirm that it is a single pulse. All stimulus changes on falling edges, so each sample sits half a cycle away from the edge that produced it.

// File: rtl/ds_pkg.sv
package ds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PUSH_HI  = 2'd1,
        ST_POP_LO   = 2'd2,
        ST_POP_DONE = 2'd3
    } stk_state_t;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_RF   = 2'd1,
        REG_IO   = 2'd2,
        REG_SRAM = 2'd3
    } region_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LATCH = 2'd1,
        SRC_SRAM  = 2'd2
    } rd_src_t;
endpackage

// File: rtl/ds_region_decode.sv
module ds_region_decode
    import ds_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int RF_COUNT   = 32,
    parameter int IO_COUNT   = 64,
    parameter int SRAM_DEPTH = 256,
    localparam int IDX_W     = $clog2(SRAM_DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [IDX_W-1:0]  sram_idx
);
    localparam int SRAM_BASE = RF_COUNT + IO_COUNT;

    logic [ADDR_W-1:0] off;

    always_comb begin
        off      = addr - ADDR_W'(SRAM_BASE);
        sram_idx = off[IDX_W-1:0];
        if (addr < ADDR_W'(RF_COUNT))
            region = REG_RF;
        else if (addr < ADDR_W'(SRAM_BASE))
            region = REG_IO;
        else if (off < ADDR_W'(SRAM_DEPTH))
            region = REG_SRAM;
        else
            region = REG_NONE;
    end
endmodule

// File: rtl/ds_sram.sv
module ds_sram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) rdata <= mem[idx];
    end
endmodule

// File: rtl/ds_stack_ctrl.sv
module ds_stack_ctrl
    import ds_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int DATA_W = 8,
    localparam int LANES = SP_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              call_push,
    input  logic              ret_pop,
    input  logic [DATA_W-1:0] push_data,
    input  logic [SP_W-1:0]   ret_in,
    input  logic [LANES-1:0]  sp_wr,
    input  logic [DATA_W-1:0] sp_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              st_we,
    output logic              st_re,
    output logic [SP_W-1:0]   st_addr,
    output logic [DATA_W-1:0] st_wdata,
    output logic [SP_W-1:0]   sp,
    output logic              busy,
    output logic [SP_W-1:0]   ret_out,
    output logic              ret_valid
);
    stk_state_t        state, state_n;
    logic [SP_W-1:0]   sp_n;
    logic [DATA_W-1:0] hi_q;

    always_comb begin
        state_n  = state;
        sp_n     = sp;
        st_we    = 1'b0;
        st_re    = 1'b0;
        st_addr  = sp;
        st_wdata = push_data;
        unique case (state)
            ST_IDLE: begin
                if (call_push) begin
                    st_we    = 1'b1;
                    st_wdata = ret_in[DATA_W-1:0];
                    sp_n     = sp - SP_W'(1);
                    state_n  = ST_PUSH_HI;
                end else if (ret_pop) begin
                    st_re   = 1'b1;
                    st_addr = sp + SP_W'(1);
                    sp_n    = sp + SP_W'(1);
                    state_n = ST_POP_LO;
                end else if (push) begin
                    st_we = 1'b1;
                    sp_n  = sp - SP_W'(1);
                end else if (pop) begin
                    st_re   = 1'b1;
                    st_addr = sp + SP_W'(1);
                    sp_n    = sp + SP_W'(1);
                end else begin
                    for (int b = 0; b < LANES; b++)
                        if (sp_wr[b]) sp_n[b*DATA_W +: DATA_W] = sp_wdata;
                end
            end
            ST_PUSH_HI: begin
                st_we    = 1'b1;
                st_wdata = hi_q;
                sp_n     = sp - SP_W'(1);
                state_n  = ST_IDLE;
            end
            ST_POP_LO: begin
                st_re   = 1'b1;
                st_addr = sp + SP_W'(1);
                sp_n    = sp + SP_W'(1);
                state_n = ST_POP_DONE;
            end
            ST_POP_DONE: state_n = ST_IDLE;
        endcase
    end

    // state register and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sp    <= '0;
        end else begin
            state <= state_n;
            sp    <= sp_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q      <= '0;
            ret_out   <= '0;
            ret_valid <= 1'b0;
        end else begin
            ret_valid <= (state == ST_POP_DONE);
            if (state == ST_IDLE && call_push)
                hi_q <= ret_in[SP_W-1:DATA_W];
            else if (state == ST_POP_LO)
                hi_q <= mem_rdata;
            if (state == ST_POP_DONE)
                ret_out <= {hi_q, mem_rdata};
        end
    end

    assign busy = (state != ST_IDLE);

    assert_push_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && push && !call_push && !ret_pop) |=> (sp == $past(sp) - SP_W'(1)));

    assert_pop_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pop && !push && !call_push && !ret_pop) |=> (sp == $past(sp) + SP_W'(1)));

    assert_call_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_HI) |=> (state == ST_IDLE && sp == $past(sp) - SP_W'(1)));

    assert_ret_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ($past(state) == ST_POP_DONE));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_DONE) |=> $stable(sp));
endmodule

// File: rtl/ds_stack_unit.sv
module ds_stack_unit
    import ds_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int RF_COUNT   = 32,
    parameter int IO_COUNT   = 64,
    parameter int SRAM_DEPTH = 256,
    parameter int SP_LO_IO   = 61,
    parameter int SP_HI_IO   = 62
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic              push,
    input  logic              pop,
    input  logic              call_push,
    input  logic              ret_pop,
    input  logic [ADDR_W-1:0] ret_addr_in,
    output logic [DATA_W-1:0] rdata,
    output logic              sel_rf,
    output logic              sel_io,
    output logic              sel_sram,
    output logic [5:0]        io_addr,
    output logic [ADDR_W-1:0] ret_addr_out,
    output logic              ret_valid,
    output logic [ADDR_W-1:0] sp_out,
    output logic              sp_err,
    output logic              busy
);
    localparam int IDX_W      = $clog2(SRAM_DEPTH);
    localparam int SRAM_BASE  = RF_COUNT + IO_COUNT;
    localparam int SP_LO_ADDR = RF_COUNT + SP_LO_IO;
    localparam int SP_HI_ADDR = RF_COUNT + SP_HI_IO;

    region_t           bus_region, mem_region;
    logic [IDX_W-1:0]  bus_idx_unused_free, mem_idx;
    logic              any_req, bus_ok, byte_pop_go;
    logic              st_we, st_re, st_active;
    logic [ADDR_W-1:0] st_addr, mem_addr;
    logic [DATA_W-1:0] st_wdata, mem_wdata, mem_rdata;
    logic              mem_we, mem_re;
    logic [1:0]        sp_wr;
    rd_src_t           rd_src;
    logic [DATA_W-1:0] rd_latch;

    ds_region_decode #(.ADDR_W(ADDR_W), .RF_COUNT(RF_COUNT), .IO_COUNT(IO_COUNT),
                       .SRAM_DEPTH(SRAM_DEPTH)) u_bus_dec (
        .addr(addr), .region(bus_region), .sram_idx(bus_idx_unused_free));

    ds_region_decode #(.ADDR_W(ADDR_W), .RF_COUNT(RF_COUNT), .IO_COUNT(IO_COUNT),
                       .SRAM_DEPTH(SRAM_DEPTH)) u_mem_dec (
        .addr(mem_addr), .region(mem_region), .sram_idx(mem_idx));

    assign sel_rf   = (bus_region == REG_RF);
    assign sel_io   = (bus_region == REG_IO);
    assign sel_sram = (bus_region == REG_SRAM);
    assign io_addr  = 6'(addr[6:0] - 7'(RF_COUNT));

    assign any_req     = push | pop | call_push | ret_pop;
    assign bus_ok      = !busy && !any_req;
    assign byte_pop_go = !busy && pop && !push && !call_push && !ret_pop;
    assign sp_wr[0]    = bus_ok && wr_en && (addr == ADDR_W'(SP_LO_ADDR));
    assign sp_wr[1]    = bus_ok && wr_en && (addr == ADDR_W'(SP_HI_ADDR));

    ds_stack_ctrl #(.SP_W(ADDR_W), .DATA_W(DATA_W)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(push), .pop(pop), .call_push(call_push), .ret_pop(ret_pop),
        .push_data(wdata), .ret_in(ret_addr_in),
        .sp_wr(sp_wr), .sp_wdata(wdata), .mem_rdata(mem_rdata),
        .st_we(st_we), .st_re(st_re), .st_addr(st_addr), .st_wdata(st_wdata),
        .sp(sp_out), .busy(busy), .ret_out(ret_addr_out), .ret_valid(ret_valid));

    assign st_active = st_we | st_re;
    assign mem_addr  = st_active ? st_addr : addr;
    assign mem_wdata = st_active ? st_wdata : wdata;
    assign mem_we    = (mem_region == REG_SRAM) && (st_active ? st_we : (bus_ok && wr_en));
    assign mem_re    = (mem_region == REG_SRAM) && (st_active ? st_re : (bus_ok && rd_en));

    ds_sram #(.DATA_W(DATA_W), .DEPTH(SRAM_DEPTH)) u_sram (
        .clk(clk), .we(mem_we), .re(mem_re), .idx(mem_idx),
        .wdata(mem_wdata), .rdata(mem_rdata));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_src   <= SRC_NONE;
            rd_latch <= '0;
        end else if (byte_pop_go) begin
            rd_src <= SRC_SRAM;
        end else if (bus_ok && rd_en) begin
            rd_src <= SRC_LATCH;
            unique case (bus_region)
                REG_RF:   rd_latch <= rf_rdata;
                REG_IO: begin
                    if (addr == ADDR_W'(SP_LO_ADDR))      rd_latch <= sp_out[DATA_W-1:0];
                    else if (addr == ADDR_W'(SP_HI_ADDR)) rd_latch <= sp_out[ADDR_W-1:DATA_W];
                    else                                  rd_latch <= io_rdata;
                end
                REG_SRAM: rd_src   <= SRC_SRAM;
                REG_NONE: rd_latch <= '0;
            endcase
        end
    end

    always_comb begin
        unique case (rd_src)
            SRC_SRAM:  rdata = mem_rdata;
            SRC_LATCH: rdata = rd_latch;
            default:   rdata = '0;
        endcase
    end

    assign sp_err = (sp_out < ADDR_W'(SRAM_BASE));

    assert_sp_lo_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr[0] |=> (sp_out[DATA_W-1:0] == $past(wdata)));

    assert_sel_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rf, sel_io, sel_sram}));

    assert_bus_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_active) |-> !mem_we);
endmodule

// File: tb/ds_stack_unit_bench.sv
`timescale 1ns/1ps
module ds_stack_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  rf_rdata, io_rdata;
    logic        push = 1'b0, pop = 1'b0, call_push = 1'b0, ret_pop = 1'b0;
    logic [15:0] ret_addr_in = '0;
    logic [7:0]  rdata;
    logic        sel_rf, sel_io, sel_sram;
    logic [5:0]  io_addr;
    logic [15:0] ret_addr_out, sp_out;
    logic        ret_valid, sp_err, busy;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign rf_rdata = 8'hA0 ^ addr[7:0];
    assign io_rdata = 8'h5A ^ addr[7:0];

    ds_stack_unit u_ds_stack_unit (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
        .rf_rdata(rf_rdata), .io_rdata(io_rdata), .push(push), .pop(pop),
        .call_push(call_push), .ret_pop(ret_pop), .ret_addr_in(ret_addr_in),
        .rdata(rdata), .sel_rf(sel_rf), .sel_io(sel_io), .sel_sram(sel_sram),
        .io_addr(io_addr), .ret_addr_out(ret_addr_out), .ret_valid(ret_valid),
        .sp_out(sp_out), .sp_err(sp_err), .busy(busy));

    // {we, re, addr[15:0], wdata[7:0], expected[7:0]}
    localparam int NVEC = 16;
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 16'h0005, 8'h00, 8'hA5},
        {1'b0, 1'b1, 16'h001F, 8'h00, 8'hBF},
        {1'b0, 1'b1, 16'h0020, 8'h00, 8'h7A},
        {1'b0, 1'b1, 16'h005F, 8'h00, 8'h05},
        {1'b1, 1'b0, 16'h0060, 8'h11, 8'h00},
        {1'b1, 1'b0, 16'h015F, 8'h22, 8'h00},
        {1'b1, 1'b0, 16'h0070, 8'h33, 8'h00},
        {1'b0, 1'b1, 16'h0060, 8'h00, 8'h11},
        {1'b0, 1'b1, 16'h015F, 8'h00, 8'h22},
        {1'b0, 1'b1, 16'h0070, 8'h00, 8'h33},
        {1'b0, 1'b1, 16'h0160, 8'h00, 8'h00},
        {1'b1, 1'b0, 16'h005D, 8'h40, 8'h00},
        {1'b1, 1'b0, 16'h005E, 8'h01, 8'h00},
        {1'b0, 1'b1, 16'h005D, 8'h00, 8'h40},
        {1'b0, 1'b1, 16'h005E, 8'h00, 8'h01},
        {1'b0, 1'b1, 16'h0040, 8'h00, 8'h1A}
    };

    function automatic string vec_req(int i);
        if (i < 2)  return "R1";
        if (i < 4)  return "R2";
        if (i < 11) return "R3";
        if (i < 15) return "R5";
        return "R2";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        check(sp_out == 16'h0000, "R4", sp_out, 16'h0000);
        check(sp_err == 1'b1, "R4", sp_err, 1);
        check(busy == 1'b0 && ret_valid == 1'b0, "R4", {busy, ret_valid}, 0);

        // combinational decode, R1 R2 R3
        addr = 16'h001F; #0.1;
        check({sel_rf, sel_io, sel_sram} == 3'b100, "R1", {sel_rf, sel_io, sel_sram}, 3'b100);
        addr = 16'h0020; #0.1;
        check({sel_rf, sel_io, sel_sram} == 3'b010 && io_addr == 6'h00, "R2", {sel_rf, sel_io, sel_sram, io_addr}, 9'b010_000000);
        addr = 16'h005F; #0.1;
        check({sel_rf, sel_io, sel_sram} == 3'b010 && io_addr == 6'h3F, "R2", {sel_rf, sel_io, sel_sram, io_addr}, 9'b010_111111);
        addr = 16'h0060; #0.1;
        check({sel_rf, sel_io, sel_sram} == 3'b001, "R3", {sel_rf, sel_io, sel_sram}, 3'b001);
        addr = 16'h0160; #0.1;
        check({sel_rf, sel_io, sel_sram} == 3'b000, "R3", {sel_rf, sel_io, sel_sram}, 3'b000);
        @(negedge clk);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            addr  = VEC[i][31:16];
            wdata = VEC[i][15:8];
            wr_en = VEC[i][33];
            rd_en = VEC[i][32];
            @(negedge clk);
            if (VEC[i][32]) check(rdata == VEC[i][7:0], vec_req(i), rdata, VEC[i][7:0]);
            wr_en = 1'b0; rd_en = 1'b0;
        end
        check(sp_out == 16'h0140 && sp_err == 1'b0, "R5", sp_out, 16'h0140);

        // R6 byte push
        wdata = 8'hC3; push = 1'b1;
        @(negedge clk);
        push = 1'b0;
        check(sp_out == 16'h013F, "R6", sp_out, 16'h013F);
        bus_rd(16'h0140, d);
        check(d == 8'hC3, "R6", d, 8'hC3);

        // R7 byte pop
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check(rdata == 8'hC3 && sp_out == 16'h0140, "R7", {rdata, sp_out}, {8'hC3, 16'h0140});

        // R8 return-address push
        ret_addr_in = 16'hBEEF; call_push = 1'b1;
        @(negedge clk);
        call_push = 1'b0;
        check(busy == 1'b1 && sp_out == 16'h013F, "R8", {busy, sp_out}, {1'b1, 16'h013F});
        @(negedge clk);
        check(busy == 1'b0 && sp_out == 16'h013E, "R8", {busy, sp_out}, {1'b0, 16'h013E});
        bus_rd(16'h0140, d);
        check(d == 8'hEF, "R8", d, 8'hEF);
        bus_rd(16'h013F, d);
        check(d == 8'hBE, "R8", d, 8'hBE);

        // R9 return-address pop
        ret_pop = 1'b1;
        @(negedge clk);
        ret_pop = 1'b0;
        check(busy == 1'b1 && ret_valid == 1'b0, "R9", {busy, ret_valid}, 2'b10);
        @(negedge clk);
        check(busy == 1'b1 && ret_valid == 1'b0, "R9", {busy, ret_valid}, 2'b10);
        @(negedge clk);
        check(ret_valid == 1'b1 && ret_addr_out == 16'hBEEF, "R9", {ret_valid, ret_addr_out}, {1'b1, 16'hBEEF});
        check(busy == 1'b0 && sp_out == 16'h0140, "R9", {busy, sp_out}, {1'b0, 16'h0140});
        @(negedge clk);
        check(ret_valid == 1'b0, "R9", ret_valid, 0);

        // R10 request during busy is ignored
        ret_addr_in = 16'h1234; call_push = 1'b1;
        @(negedge clk);
        call_push = 1'b0; wdata = 8'h77; push = 1'b1;
        @(negedge clk);
        push = 1'b0;
        check(sp_out == 16'h013E, "R10", sp_out, 16'h013E);

        // R10 bus write in a stack-request cycle is dropped
        addr = 16'h0070; wdata = 8'h99; wr_en = 1'b1; push = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; push = 1'b0;
        check(sp_out == 16'h013D, "R10", sp_out, 16'h013D);
        bus_rd(16'h0070, d);
        check(d == 8'h33, "R10", d, 8'h33);
        bus_rd(16'h013E, d);
        check(d == 8'h99, "R10", d, 8'h99);

        // R4 error flag boundary
        bus_wr(16'h005E, 8'h00);
        bus_wr(16'h005D, 8'h5F);
        check(sp_out == 16'h005F && sp_err == 1'b1, "R4", {sp_err, sp_out}, {1'b1, 16'h005F});
        bus_wr(16'h005D, 8'h60);
        check(sp_out == 16'h0060 && sp_err == 1'b0, "R4", {sp_err, sp_out}, {1'b0, 16'h0060});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule